// File: doc/BRIEF.md
# Frame Writeback DMA Controller

The block captures one frame from an incoming pixel stream and stores it in memory as raster lines. Software programs a destination base address, a line pitch in bytes and the frame dimensions (in 32-bit pixel words) through a small 32-bit register file. It then sets a start bit. The engine moves each accepted pixel word to a word-write memory request port that has a ready handshake. Lines are placed pitch bytes apart.

A busy flag tracks the frame. An idle interrupt signals completion, and software acknowledges it by clearing the interrupt enable. An abort control ends a frame at once. A power-down control keeps the engine from starting. A progress register counts lines fully committed to memory. Pixel packing and any interconnect protocol belong to neighbouring blocks.

Top module: `frame_wb_dma`

## Requirements
- R1: After reset, the base, pitch, dimension and progress registers (offsets 0x00, 0x04, 0x08, 0x10) read 0. The control word (offset 0x0C) reads 0x54400000, and irq_o and mem_req_o are low.
- R2: In the control word, bits 31:24 always read 0x54 and bits 23:22 always read 1, whatever is written. Base bits 1:0 and pitch bits 3:0 read as zero. The dimension word keeps the height in bits 31:16 and the width in bits 15:0.
- R3: Writing a control word with bit 0 set starts a frame. Bit 0 always reads 0. Busy (bit 1) reads 1 from the cycle after the starting write, and reads 0 from the cycle after the last word of the frame is accepted.
- R4: The k-th word of line n is written to base + n*pitch + 4*k and carries the pixel word accepted with it. A frame issues exactly width*height writes, in raster order.
- R5: Progress reads 0 after a start. It rises by one when the last word of each line is accepted, so it reads the height at the end of a complete frame.
- R6: mem_req_o is high only while busy and pix_valid_i is high. pix_ready_o equals busy and mem_ready_i, so no request is issued while idle.
- R7: With the interrupt enable (bit 2) set, irq_o rises in the same cycle that busy falls. It stays high until a control write with bit 2 clear. With bit 2 clear, no interrupt is raised.
- R8: A control write with bit 14 set while busy clears busy in the next cycle. No memory write follows, and progress keeps the count of completed lines.
- R9: A start request is ignored while busy, while powered down, or while the width or height is zero. A request ignored while busy leaves the running frame's addresses and progress intact.
- R10: Control bit 21 (power-down) and bit 2 (interrupt enable) are stored and read back. All other control bits except busy and the fixed fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| pix_valid_i | input | 1 | Pixel word valid |
| pix_data_i | input | DW | Pixel word |
| pix_ready_o | output | 1 | Pixel word consumed |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory byte address |
| mem_data_o | output | DW | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| irq_o | output | 1 | Idle interrupt |

## Verification
The bench builds the block with its default 32-bit pixel word and 16-bit dimension counters. Random stall patterns are applied on both the pixel valid and the memory ready. The frames used are small (1 to 8 words wide, 1 to 5 lines high), so every line wrap, frame end, a single-word frame and an abort in the middle of a line are each reached many times within the cycle budget. Random bases and 16-byte-multiple pitches test the address arithmetic over the full 32-bit range.

// File: rtl/fwb_pkg.sv
`timescale 1ns/1ps
package fwb_pkg;
  localparam int REG_W = 32;
  localparam int OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_BASE  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_PITCH = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DIM   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_PROG  = 5'h10;

  localparam int CB_GO    = 0;
  localparam int CB_BUSY  = 1;
  localparam int CB_IE    = 2;
  localparam int CB_ABORT = 14;
  localparam int CB_PD    = 21;

  localparam logic [7:0] ID_MAGIC = 8'h54;
  localparam logic [1:0] ID_REV   = 2'h1;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] pitch;
    logic [15:0]      height;
    logic [15:0]      width;
  } frame_cfg_t;
endpackage

// File: rtl/fwb_regs.sv
`timescale 1ns/1ps
module fwb_regs
  import fwb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [CW-1:0]     progress_i,
  output frame_cfg_t        cfg_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              pd_o,
  output logic              irq_o
);
  frame_cfg_t cfg_q;
  logic       ie_q, pd_q, irq_q;
  logic       ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == OFS_CTRL);
  // start honours the power-down state held before this write
  assign start_o = ctrl_wr && wdata_i[CB_GO] && !busy_i && !pd_q &&
                   (cfg_q.width != '0) && (cfg_q.height != '0);
  assign abort_o = ctrl_wr && wdata_i[CB_ABORT] && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ie_q  <= 1'b0;
      pd_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          OFS_BASE:  cfg_q.base  <= {wdata_i[REG_W-1:2], 2'b00};
          OFS_PITCH: cfg_q.pitch <= {wdata_i[REG_W-1:4], 4'h0};
          OFS_DIM:   {cfg_q.height, cfg_q.width} <= wdata_i;
          OFS_CTRL: begin
            ie_q <= wdata_i[CB_IE];
            pd_q <= wdata_i[CB_PD];
          end
          default: ;
        endcase
      end
      if (ctrl_wr && !wdata_i[CB_IE]) irq_q <= 1'b0;
      else if (fin_i && ie_q)         irq_q <= 1'b1;
    end
  end

  logic [REG_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[31:24]   = ID_MAGIC;
    ctrl_rd[23:22]   = ID_REV;
    ctrl_rd[CB_PD]   = pd_q;
    ctrl_rd[CB_IE]   = ie_q;
    ctrl_rd[CB_BUSY] = busy_i;
  end

  always_comb begin
    unique case (addr_i)
      OFS_BASE:  rdata_o = cfg_q.base;
      OFS_PITCH: rdata_o = cfg_q.pitch;
      OFS_DIM:   rdata_o = {cfg_q.height, cfg_q.width};
      OFS_CTRL:  rdata_o = ctrl_rd;
      OFS_PROG:  rdata_o = REG_W'(progress_i);
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign pd_o  = pd_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/fwb_engine.sv
`timescale 1ns/1ps
module fwb_engine
  import fwb_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_cfg_t       cfg_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             pix_valid_i,
  input  logic [DW-1:0]    pix_data_i,
  output logic             pix_ready_o,
  output logic             mem_req_o,
  output logic [REG_W-1:0] mem_addr_o,
  output logic [DW-1:0]    mem_data_o,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [CW-1:0]    progress_o
);
  localparam int          BPW  = DW / 8;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic             busy_q;
  logic [CW-1:0]    x_q, y_q, w_q, h_q, prog_q;
  logic [REG_W-1:0] line_q, addr_q, pitch_q;
  logic             accept, eol, eof;

  assign mem_req_o   = busy_q && pix_valid_i;
  assign pix_ready_o = busy_q && mem_ready_i;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = pix_data_i;
  assign accept      = mem_req_o && mem_ready_i;
  assign eol         = (x_q == w_q - ONE);
  assign eof         = eol && (y_q == h_q - ONE);
  assign fin_o       = busy_q && (abort_i || (accept && eof));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      w_q     <= '0;
      h_q     <= '0;
      prog_q  <= '0;
      line_q  <= '0;
      addr_q  <= '0;
      pitch_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      x_q     <= '0;
      y_q     <= '0;
      w_q     <= cfg_i.width[CW-1:0];
      h_q     <= cfg_i.height[CW-1:0];
      prog_q  <= '0;
      line_q  <= cfg_i.base;
      addr_q  <= cfg_i.base;
      pitch_q <= cfg_i.pitch;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      if (eol) begin
        x_q    <= '0;
        y_q    <= y_q + ONE;
        line_q <= line_q + pitch_q;
        addr_q <= line_q + pitch_q;
        prog_q <= prog_q + ONE;
        if (eof) busy_q <= 1'b0;
      end else begin
        x_q    <= x_q + ONE;
        addr_q <= addr_q + REG_W'(BPW);
      end
    end
  end

  assign busy_o     = busy_q;
  assign progress_o = prog_q;
endmodule

// File: rtl/frame_wb_dma.sv
`timescale 1ns/1ps
module frame_wb_dma
  import fwb_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              pix_valid_i,
  input  logic [DW-1:0]     pix_data_i,
  output logic              pix_ready_o,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  output logic [DW-1:0]     mem_data_o,
  input  logic              mem_ready_i,
  output logic              irq_o
);
  frame_cfg_t    cfg;
  logic          start, abort, busy, fin, pd;
  logic [CW-1:0] progress;

  fwb_regs #(.CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .fin_i      (fin),
    .progress_i (progress),
    .cfg_o      (cfg),
    .start_o    (start),
    .abort_o    (abort),
    .pd_o       (pd),
    .irq_o      (irq_o)
  );

  fwb_engine #(.DW(DW), .CW(CW)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .start_i     (start),
    .abort_i     (abort),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .pix_ready_o (pix_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy),
    .fin_o       (fin),
    .progress_o  (progress)
  );
endmodule

// File: rtl/fwb_checker.sv
`timescale 1ns/1ps
module fwb_checker #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [4:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          busy_i,
  input logic          pd_i,
  input logic [15:0]   w_i,
  input logic [15:0]   h_i,
  input logic          irq_i,
  input logic          mem_req_i,
  input logic [CW-1:0] progress_i
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == 5'h0C);

  assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[0] && !busy_i && !pd_i && w_i != 0 && h_i != 0)
    |=> (busy_i && progress_i == '0));

  assert_pd_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && pd_i) |=> !busy_i);

  assert_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[14] && busy_i) |=> (!busy_i && !mem_req_i));

  assert_irq_at_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $fell(busy_i));

  assert_progress_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |->
      (progress_i == $past(progress_i) || progress_i == $past(progress_i) + 1'b1));

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_req_i);
endmodule

bind frame_wb_dma fwb_checker #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .busy_i     (busy),
  .pd_i       (pd),
  .w_i        (cfg.width),
  .h_i        (cfg.height),
  .irq_i      (irq_o),
  .mem_req_i  (mem_req_o),
  .progress_i (progress)
);

// File: tb/frame_wb_dma_bench.sv
`timescale 1ns/1ps
module frame_wb_dma_bench;
  localparam logic [4:0] A_BASE = 5'h00, A_PITCH = 5'h04, A_DIM = 5'h08,
                         A_CTRL = 5'h0C, A_PROG = 5'h10;
  localparam logic [31:0] GO = 32'h1, IE = 32'h4, ABORT = 32'h4000, PD = 32'h20_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        pix_valid = 1'b0, pix_ready;
  logic [31:0] pix_data = '0;
  logic        mem_req, mem_ready = 1'b0, irq;
  logic [31:0] mem_addr, mem_data;
  int          errs = 0, checks = 0;

  always #4 clk = ~clk;

  frame_wb_dma u_frame_wb_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pix_valid_i(pix_valid),
    .pix_data_i(pix_data), .pix_ready_o(pix_ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ready_i(mem_ready),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [31:0] p,
                                           input int y, input int x);
    return b + p * 32'(y) + 32'(4 * x);
  endfunction

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; pix_valid = 1'b0;
    next_cycle();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic run_frame(input logic [31:0] base, input logic [31:0] pitch,
                           input int w, input int h, input bit ie,
                           input int abort_at, input int rego_at);
    logic [31:0] v;
    int x = 0, y = 0, n = 0, guard = 0;
    bit aborted = 0, regone = 0;
    wr(A_BASE, base); wr(A_PITCH, pitch); wr(A_DIM, {16'(h), 16'(w)});
    wr(A_CTRL, GO | (ie ? IE : 0));
    rd(A_CTRL, v);
    chk(v[1] == 1'b1, "R3 busy after start", v, v | 32'h2);
    chk(v[0] == 1'b0, "R3 go self-clears", v, v & ~32'h1);
    rd(A_PROG, v);
    chk(v == 0, "R5 progress cleared at start", v, 0);
    while (guard < 20000) begin
      guard++;
      reg_addr = A_CTRL; reg_we = 1'b0;
      pix_valid = ($urandom % 4) != 0;
      pix_data  = $urandom;
      mem_ready = ($urandom % 3) != 0;
      #2;
      if (!reg_rdata[1]) break;
      chk(mem_req == pix_valid, "R6 request follows valid", 32'(mem_req), 32'(pix_valid));
      chk(pix_ready == mem_ready, "R6 ready follows memory", 32'(pix_ready), 32'(mem_ready));
      if (mem_req && mem_ready) begin
        chk(mem_addr == exp_addr(base, pitch, y, x), "R4 address", mem_addr,
            exp_addr(base, pitch, y, x));
        chk(mem_data == pix_data, "R4 data", mem_data, pix_data);
        n++;
        if (x == w - 1) begin x = 0; y++; end else x++;
      end
      next_cycle();
      if (abort_at >= 0 && n == abort_at) begin
        wr(A_CTRL, ABORT | (ie ? IE : 0));
        aborted = 1;
        break;
      end
      if (rego_at >= 0 && n == rego_at && !regone) begin
        wr(A_CTRL, GO | (ie ? IE : 0)); // R9: ignored while busy
        regone = 1;
      end
    end
    rd(A_CTRL, v);
    chk(v[1] == 1'b0, aborted ? "R8 busy cleared by abort" : "R3 busy clears", v, v & ~32'h2);
    rd(A_PROG, v);
    if (aborted) chk(v == 32'(n / w), "R8 progress kept after abort", v, 32'(n / w));
    else begin
      chk(n == w * h, "R4 write count", 32'(n), 32'(w * h));
      chk(v == 32'(h), "R5 progress equals height", v, 32'(h));
    end
    chk(irq == ie, "R7 irq at idle", 32'(irq), 32'(ie));
    for (int i = 0; i < 3; i++) begin
      pix_valid = 1'b1; mem_ready = 1'b1; #1;
      chk(!mem_req && !pix_ready, "R6 quiet when idle", 32'(mem_req), 0);
      next_cycle();
    end
    pix_valid = 1'b0;
    if (ie) begin
      wr(A_CTRL, IE);
      chk(irq == 1'b1, "R7 irq held while enable kept", 32'(irq), 1);
      wr(A_CTRL, 0);
      chk(irq == 1'b0, "R7 irq cleared by enable low", 32'(irq), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    next_cycle();
    // R1 reset state
    rd(A_BASE, v);  chk(v == 0, "R1 base reset", v, 0);
    rd(A_PITCH, v); chk(v == 0, "R1 pitch reset", v, 0);
    rd(A_DIM, v);   chk(v == 0, "R1 dim reset", v, 0);
    rd(A_PROG, v);  chk(v == 0, "R1 progress reset", v, 0);
    rd(A_CTRL, v);  chk(v == 32'h5440_0000, "R1 ctrl reset", v, 32'h5440_0000);
    pix_valid = 1'b1; #1;
    chk(!irq && !mem_req, "R1 outputs idle", {30'd0, irq, mem_req}, 0);
    pix_valid = 1'b0;
    // R2 field masking, R10 stored bits, R9 zero dims ignore start
    wr(A_BASE, 32'hFFFF_FFFF);  rd(A_BASE, v);  chk(v == 32'hFFFF_FFFC, "R2 base align", v, 32'hFFFF_FFFC);
    wr(A_PITCH, 32'hFFFF_FFFF); rd(A_PITCH, v); chk(v == 32'hFFFF_FFF0, "R2 pitch align", v, 32'hFFFF_FFF0);
    wr(A_DIM, 32'h0003_0000);   rd(A_DIM, v);   chk(v == 32'h0003_0000, "R2 dim fields", v, 32'h0003_0000);
    wr(A_CTRL, 32'hFFFF_FFFF);  rd(A_CTRL, v);
    chk(v == 32'h5460_0004, "R2 R10 ctrl readback, R9 zero width", v, 32'h5460_0004);
    wr(A_CTRL, 0); rd(A_CTRL, v); chk(v == 32'h5440_0000, "R10 ctrl cleared", v, 32'h5440_0000);
    // R9 power-down blocks start
    wr(A_DIM, 32'h0002_0002); wr(A_CTRL, PD); wr(A_CTRL, GO | PD);
    rd(A_CTRL, v); chk(v[1] == 1'b0, "R9 start ignored when powered down", v, 32'h5460_0000);
    wr(A_CTRL, 0);
    // directed frames
    run_frame(32'h0000_1000, 32'h40, 5, 3, 1'b1, -1, -1);
    run_frame(32'h0000_2000, 32'h10, 1, 1, 1'b1, -1, -1);
    run_frame(32'h8000_0000, 32'h100, 4, 5, 1'b1, 7, -1);
    run_frame(32'h0000_3000, 32'h20, 3, 3, 1'b0, -1, 3);
    run_frame(32'hFFFF_FFF0, 32'h30, 4, 2, 1'b0, -1, -1);
    // random frames
    for (int k = 0; k < 12; k++) begin
      run_frame($urandom & 32'hFFFF_FFFC, (($urandom % 64) + 1) * 16,
                ($urandom % 8) + 1, ($urandom % 5) + 1, 1'($urandom % 2),
                (k % 4 == 3) ? 2 : -1, -1);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule